// File: doc/BRIEF.md
# Pixel Quad Warp Packer

The packer gathers a stream of rasterized 2x2 pixel quads into 32-lane pixel-shading warps of eight quads each. A quad is never split: all four of its lanes travel together into one warp slot. Lanes whose sample does not cover the primitive are still placed in the warp, but they are marked in a helper mask instead of the coverage mask. Helper lanes keep the quad complete, so the quad's neighbouring lanes can still be used for lock-step differences. Quads with no covered sample are discarded before packing.

Each incoming quad also passes through a derivative unit. The unit forms horizontal and vertical differences between lanes of the same quad. These differences are stored with the quad, so the finished warp carries per-lane attributes and per-lane derivative pairs. A warp is presented when all eight slots are filled, or early when an end-of-batch marker arrives. In the early case, the warp reports how many slots are valid, and the unused slots read as zero.

The quad input uses a valid/ready handshake, and so does the warp output. While a finished warp is waiting for the consumer, the input is held off.

Top module: `quad_warp_packer`

## Requirements
- R1: After synchronous reset, out_valid is 0, in_ready is 1, out_count is 0, and out_cov and out_help are all zero.
- R2: Kept quads fill slots 0, 1, 2 … in arrival order. Slot s reports the quad position at out_qx/out_qy bits [s*XW +: XW]. Its lanes occupy warp lanes 4s..4s+3, in the order top-left, top-right, bottom-left, bottom-right. These four lanes correspond to in_cov bits 0..3 and to in_attr bytes 0..3.
- R3: For a kept quad, the helper bits of its four lanes are the inverse of its coverage bits. Every lane of a used slot is therefore either covered or a helper, and never both.
- R4: A quad whose in_cov is 4'b0000 is accepted (in_ready stays 1) but takes no slot and is not counted.
- R5: When the eighth quad is kept, out_valid is 1 from the next cycle, with out_count = 8.
- R6: When a quad with in_last = 1 is accepted and at least one quad is buffered afterwards, a partial warp is presented from the next cycle. Its out_count equals the number of kept quads. Unused slots have zero coverage, helper, position, attribute and derivative fields.
- R7: An in_last quad with zero coverage that arrives when no quad is buffered produces no warp.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and every warp output stays unchanged.
- R9: Horizontal derivative (out_ddx, 9-bit two's complement per lane, attributes taken as unsigned): lanes 0 and 1 of a quad get a1−a0, and lanes 2 and 3 get a3−a2.
- R10: Vertical derivative (out_ddy, same format): lanes 0 and 2 get a2−a0, and lanes 1 and 3 get a3−a1.
- R11: The cycle after a warp handshake (out_valid and out_ready both 1), out_valid is 0, in_ready is 1 and all slots are empty. The next kept quad goes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Quad offered |
| in_ready | output | 1 | Quad accepted this cycle when in_valid is 1 |
| in_qx | input | XW | Quad screen column |
| in_qy | input | XW | Quad screen row |
| in_cov | input | 4 | Per-lane coverage, bit 0 top-left … bit 3 bottom-right |
| in_attr | input | 4*AW | Per-lane attribute, lane l at bits [l*AW +: AW] |
| in_last | input | 1 | End of batch, flushes a partial warp |
| out_valid | output | 1 | Warp presented |
| out_ready | input | 1 | Consumer takes the warp |
| out_qx | output | QN*XW | Quad column per slot |
| out_qy | output | QN*XW | Quad row per slot |
| out_cov | output | 4*QN | Covered-lane mask |
| out_help | output | 4*QN | Helper-lane mask |
| out_count | output | $clog2(QN+1) | Number of valid slots |
| out_attr | output | 4*QN*AW | Per-lane attributes |
| out_ddx | output | 4*QN*(AW+1) | Per-lane horizontal difference |
| out_ddy | output | 4*QN*(AW+1) | Per-lane vertical difference |

## Verification
The bench feeds a mixed stream of quads. The stream includes a fully covered quad, single-lane quads, zero-coverage quads in the middle of a warp and at a batch end, and attribute pairs whose difference is negative. A packer that counted empty quads would close the first warp one quad early and shift every later slot. A packer that left helper bits clear, or set them on unused slots, would show a wrong helper mask. Swapped or sign-truncated difference operands show up as wrong ddx/ddy values in the 0x00/0xFF and 0x80 cases. The bench also holds the consumer off for a cycle to check that the input is stalled and the warp is stable. It checks that a batch end with nothing buffered emits no empty warp, and that after each handshake the next warp starts again at slot 0.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int LANES_PER_QUAD = 4;
  localparam int LANE_TL = 0;
  localparam int LANE_TR = 1;
  localparam int LANE_BL = 2;
  localparam int LANE_BR = 3;
endpackage

// File: rtl/wp_quad_deriv.sv
module wp_quad_deriv
  import wp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [LANES_PER_QUAD*AW-1:0]     attr,
  output logic [LANES_PER_QUAD*(AW+1)-1:0] ddx,
  output logic [LANES_PER_QUAD*(AW+1)-1:0] ddy
);
  localparam int DW = AW + 1;

  logic [DW-1:0] ext [LANES_PER_QUAD];
  logic [DW-1:0] dh_top, dh_bot, dv_left, dv_right;

  for (genvar l = 0; l < LANES_PER_QUAD; l++) begin : g_ext
    assign ext[l] = {1'b0, attr[l*AW +: AW]};
  end

  assign dh_top   = ext[LANE_TR] - ext[LANE_TL];
  assign dh_bot   = ext[LANE_BR] - ext[LANE_BL];
  assign dv_left  = ext[LANE_BL] - ext[LANE_TL];
  assign dv_right = ext[LANE_BR] - ext[LANE_TR];

  for (genvar l = 0; l < LANES_PER_QUAD; l++) begin : g_lane
    if (l < 2) begin : g_top
      assign ddx[l*DW +: DW] = dh_top;
    end else begin : g_bot
      assign ddx[l*DW +: DW] = dh_bot;
    end
    if ((l % 2) == 0) begin : g_left
      assign ddy[l*DW +: DW] = dv_left;
    end else begin : g_right
      assign ddy[l*DW +: DW] = dv_right;
    end
  end
endmodule

// File: rtl/wp_fill_ctrl.sv
module wp_fill_ctrl #(
  parameter int QN = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_last,
  input  logic [3:0]               in_cov,
  input  logic                     out_ready,
  output logic                     in_ready,
  output logic                     wr_en,
  output logic [$clog2(QN)-1:0]    wr_slot,
  output logic                     clr,
  output logic                     out_valid,
  output logic [$clog2(QN+1)-1:0]  count
);
  localparam int CW = $clog2(QN + 1);
  localparam int SW = $clog2(QN);

  logic          vld;
  logic [CW-1:0] cnt, nxt;
  logic          acc;

  assign in_ready = !vld;
  assign acc      = in_valid && !vld;
  assign wr_en    = acc && (in_cov != 4'b0000);
  assign wr_slot  = cnt[SW-1:0];
  assign nxt      = cnt + {{(CW-1){1'b0}}, wr_en};
  assign clr      = vld && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      cnt <= '0;
    end else if (clr) begin
      vld <= 1'b0;
      cnt <= '0;
    end else if (acc) begin
      cnt <= nxt;
      if (nxt == CW'(QN) || (in_last && nxt != '0)) vld <= 1'b1;
    end
  end

  assign out_valid = vld;
  assign count     = cnt;

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (vld && !out_ready) |=> (vld && $stable(cnt)));

  assert_cap_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(QN));

  assert_no_empty_warp_R7: assert property (@(posedge clk) disable iff (rst)
    vld |-> (cnt != '0));
endmodule

// File: rtl/wp_slot_bank.sv
module wp_slot_bank
  import wp_pkg::*;
#(
  parameter int XW = 12,
  parameter int AW = 8,
  parameter int QN = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [$clog2(QN)-1:0]                wr_slot,
  input  logic                                 clr,
  input  logic [XW-1:0]                        qx,
  input  logic [XW-1:0]                        qy,
  input  logic [LANES_PER_QUAD-1:0]            cov,
  input  logic [LANES_PER_QUAD*AW-1:0]         attr,
  input  logic [LANES_PER_QUAD*(AW+1)-1:0]     ddx,
  input  logic [LANES_PER_QUAD*(AW+1)-1:0]     ddy,
  output logic [QN*XW-1:0]                     slot_qx,
  output logic [QN*XW-1:0]                     slot_qy,
  output logic [QN*LANES_PER_QUAD-1:0]         slot_cov,
  output logic [QN*LANES_PER_QUAD-1:0]         slot_help,
  output logic [QN*LANES_PER_QUAD*AW-1:0]      slot_attr,
  output logic [QN*LANES_PER_QUAD*(AW+1)-1:0]  slot_ddx,
  output logic [QN*LANES_PER_QUAD*(AW+1)-1:0]  slot_ddy
);
  localparam int SW = $clog2(QN);
  localparam int QA = LANES_PER_QUAD * AW;
  localparam int QD = LANES_PER_QUAD * (AW + 1);
  localparam int L  = LANES_PER_QUAD;

  for (genvar s = 0; s < QN; s++) begin : g_slot
    logic [XW-1:0] r_qx, r_qy;
    logic [L-1:0]  r_cov, r_help;
    logic [QA-1:0] r_attr;
    logic [QD-1:0] r_ddx, r_ddy;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        r_qx   <= '0;
        r_qy   <= '0;
        r_cov  <= '0;
        r_help <= '0;
        r_attr <= '0;
        r_ddx  <= '0;
        r_ddy  <= '0;
      end else if (wr_en && wr_slot == SW'(s)) begin
        r_qx   <= qx;
        r_qy   <= qy;
        r_cov  <= cov;
        r_help <= ~cov;
        r_attr <= attr;
        r_ddx  <= ddx;
        r_ddy  <= ddy;
      end
    end

    assign slot_qx[s*XW +: XW]  = r_qx;
    assign slot_qy[s*XW +: XW]  = r_qy;
    assign slot_cov[s*L +: L]   = r_cov;
    assign slot_help[s*L +: L]  = r_help;
    assign slot_attr[s*QA +: QA] = r_attr;
    assign slot_ddx[s*QD +: QD] = r_ddx;
    assign slot_ddy[s*QD +: QD] = r_ddy;

    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (rst)
      clr |=> (r_cov == '0 && r_help == '0));
  end
endmodule

// File: rtl/quad_warp_packer.sv
module quad_warp_packer #(
  parameter int XW = 12,
  parameter int AW = 8,
  parameter int QN = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [XW-1:0]               in_qx,
  input  logic [XW-1:0]               in_qy,
  input  logic [3:0]                  in_cov,
  input  logic [4*AW-1:0]             in_attr,
  input  logic                        in_last,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [QN*XW-1:0]            out_qx,
  output logic [QN*XW-1:0]            out_qy,
  output logic [4*QN-1:0]             out_cov,
  output logic [4*QN-1:0]             out_help,
  output logic [$clog2(QN+1)-1:0]     out_count,
  output logic [4*QN*AW-1:0]          out_attr,
  output logic [4*QN*(AW+1)-1:0]      out_ddx,
  output logic [4*QN*(AW+1)-1:0]      out_ddy
);
  localparam int SW = $clog2(QN);
  localparam int DW = AW + 1;

  logic          wr_en, clr;
  logic [SW-1:0] wr_slot;
  logic [4*DW-1:0] q_ddx, q_ddy;

  wp_fill_ctrl #(.QN(QN)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_cov(in_cov), .out_ready(out_ready), .in_ready(in_ready),
    .wr_en(wr_en), .wr_slot(wr_slot), .clr(clr),
    .out_valid(out_valid), .count(out_count)
  );

  wp_quad_deriv #(.AW(AW)) u_deriv (
    .attr(in_attr), .ddx(q_ddx), .ddy(q_ddy)
  );

  wp_slot_bank #(.XW(XW), .AW(AW), .QN(QN)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .clr(clr),
    .qx(in_qx), .qy(in_qy), .cov(in_cov), .attr(in_attr),
    .ddx(q_ddx), .ddy(q_ddy),
    .slot_qx(out_qx), .slot_qy(out_qy), .slot_cov(out_cov),
    .slot_help(out_help), .slot_attr(out_attr),
    .slot_ddx(out_ddx), .slot_ddy(out_ddy)
  );

  assert_lane_fill_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_cov | out_help) == 4 * int'(out_count)));

  assert_lane_disjoint_R3: assert property (@(posedge clk) disable iff (rst)
    (out_cov & out_help) == '0);
endmodule

// File: tb/test_quad_warp_packer.sv
module test_quad_warp_packer;
  localparam int XW = 12;
  localparam int AW = 8;
  localparam int QN = 8;
  localparam int DW = AW + 1;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [XW-1:0] in_qx = '0, in_qy = '0;
  logic [3:0] in_cov = '0;
  logic [4*AW-1:0] in_attr = '0;
  logic in_ready, out_valid;
  logic [QN*XW-1:0] out_qx, out_qy;
  logic [4*QN-1:0] out_cov, out_help;
  logic [3:0] out_count;
  logic [4*QN*AW-1:0] out_attr;
  logic [4*QN*DW-1:0] out_ddx, out_ddy;

  always #2.5 clk = ~clk;

  quad_warp_packer #(.XW(XW), .AW(AW), .QN(QN)) i_quad_warp_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_qx(in_qx), .in_qy(in_qy), .in_cov(in_cov), .in_attr(in_attr),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_qx(out_qx), .out_qy(out_qy), .out_cov(out_cov), .out_help(out_help),
    .out_count(out_count), .out_attr(out_attr), .out_ddx(out_ddx), .out_ddy(out_ddy)
  );

  // {qx, qy, cov, attr(lane3..lane0), last}
  localparam logic [60:0] VEC [NV] = '{
    {12'd1,  12'd2, 4'hF, 32'h40302010, 1'b0},
    {12'd3,  12'd2, 4'h1, 32'h00000080, 1'b0},
    {12'd5,  12'd2, 4'h0, 32'hFFFFFFFF, 1'b0},
    {12'd7,  12'd2, 4'h6, 32'h01FF0010, 1'b0},
    {12'd9,  12'd4, 4'h8, 32'h80000000, 1'b0},
    {12'd11, 12'd4, 4'h3, 32'h12345678, 1'b0},
    {12'd13, 12'd4, 4'hC, 32'hAABBCCDD, 1'b0},
    {12'd15, 12'd4, 4'h9, 32'h0F0E0D0C, 1'b0},
    {12'd17, 12'd6, 4'h5, 32'h55AA55AA, 1'b0},
    {12'd2,  12'd8, 4'hF, 32'h01020304, 1'b0},
    {12'd4,  12'd8, 4'h2, 32'h00FF00FF, 1'b0},
    {12'd6,  12'd8, 4'h0, 32'h11111111, 1'b1},
    {12'd8,  12'd8, 4'h7, 32'h99887766, 1'b1}
  };

  int checks = 0, errors = 0, cyc = 0;
  logic [XW-1:0] e_qx [QN], e_qy [QN];
  logic [3:0] e_cov [QN];
  logic [4*AW-1:0] e_attr [QN];
  int e_cnt = 0;
  bit pending = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < QN; s++) begin
      e_qx[s] = '0; e_qy[s] = '0; e_cov[s] = '0; e_attr[s] = '0;
    end
    e_cnt = 0;
    pending = 0;
  endtask

  task automatic send(input logic [60:0] v);
    while (!in_ready) @(negedge clk);
    {in_qx, in_qy, in_cov, in_attr, in_last} = v;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    if (v[36:33] != 4'h0) begin
      e_qx[e_cnt] = v[60:49]; e_qy[e_cnt] = v[48:37];
      e_cov[e_cnt] = v[36:33]; e_attr[e_cnt] = v[32:1];
      e_cnt++;
    end
    pending = (e_cnt == QN) || (v[0] && e_cnt > 0);
  endtask

  task automatic take_warp(input string tag);
    logic [QN*XW-1:0] xq, yq;
    logic [4*QN-1:0] xc, xh;
    logic [4*QN*AW-1:0] xa;
    logic [4*QN*DW-1:0] xdx, xdy;
    logic [QN*XW-1:0] hold_qx;
    logic [4*QN-1:0] hold_cov;
    xq = '0; yq = '0; xc = '0; xh = '0; xa = '0; xdx = '0; xdy = '0;
    for (int s = 0; s < e_cnt; s++) begin
      xq[s*XW +: XW] = e_qx[s];
      yq[s*XW +: XW] = e_qy[s];
      xc[s*4 +: 4] = e_cov[s];
      xh[s*4 +: 4] = ~e_cov[s];
      xa[s*32 +: 32] = e_attr[s];
      for (int l = 0; l < 4; l++) begin
        logic [DW-1:0] b0, b1, b2, b3;
        b0 = {1'b0, e_attr[s][7:0]};   b1 = {1'b0, e_attr[s][15:8]};
        b2 = {1'b0, e_attr[s][23:16]}; b3 = {1'b0, e_attr[s][31:24]};
        xdx[(4*s+l)*DW +: DW] = (l < 2) ? b1 - b0 : b3 - b2;
        xdy[(4*s+l)*DW +: DW] = (l % 2 == 0) ? b2 - b0 : b3 - b1;
      end
    end
    chk(out_valid == 1'b1, {tag, " out_valid"}, 512'(out_valid), 512'(1));
    chk(out_count == 4'(e_cnt), {tag, " out_count"}, 512'(out_count), 512'(e_cnt));
    chk(in_ready == 1'b0, "R8 in_ready low while warp waits", 512'(in_ready), 512'(0));
    hold_qx = out_qx; hold_cov = out_cov;
    @(negedge clk);
    chk(out_valid && out_qx == hold_qx && out_cov == hold_cov,
        "R8 warp stable under stall", 512'(out_cov), 512'(hold_cov));
    chk(in_ready == 1'b0, "R8 in_ready low second stall cycle", 512'(in_ready), 512'(0));
    chk(out_qx == xq && out_qy == yq, "R2 quad positions", 512'(out_qx), 512'(xq));
    chk(out_cov == xc, "R2/R6 coverage mask", 512'(out_cov), 512'(xc));
    chk(out_help == xh, "R3/R6 helper mask", 512'(out_help), 512'(xh));
    chk(out_attr == xa, "R2/R6 lane attributes", 512'(out_attr), 512'(xa));
    chk(out_ddx == xdx, "R9 horizontal derivative", 512'(out_ddx), 512'(xdx));
    chk(out_ddy == xdy, "R10 vertical derivative", 512'(out_ddy), 512'(xdy));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R11 released after handshake",
        512'({out_valid, in_ready}), 512'(2'b01));
    chk(out_cov == '0 && out_help == '0 && out_count == '0, "R11 slots emptied",
        512'(out_cov), 512'(0));
    model_clear();
  endtask

  initial begin
    wait (cyc > 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset handshake state",
        512'({out_valid, in_ready}), 512'(2'b01));
    chk(out_count == '0 && out_cov == '0 && out_help == '0, "R1 reset slots",
        512'(out_count), 512'(0));

    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      if (pending) begin
        if (VEC[i][0]) take_warp("R6 partial warp");
        else take_warp("R5 full warp");
      end else begin
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R4 no warp before fill",
            512'({out_valid, in_ready}), 512'(2'b01));
      end
    end

    // R7: batch end with empty quad and nothing buffered
    send({12'd30, 12'd30, 4'h0, 32'h12121212, 1'b1});
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R7 no empty warp",
        512'({out_valid, in_ready}), 512'(2'b01));
    chk(out_count == '0, "R7 count stays zero", 512'(out_count), 512'(0));

    // R4: empty quads between two kept ones take no slot
    send({12'd40, 12'd1, 4'h2, 32'h0A000000, 1'b0});
    send({12'd41, 12'd1, 4'h0, 32'hFFFFFFFF, 1'b0});
    send({12'd42, 12'd1, 4'h4, 32'h00000001, 1'b1});
    chk(pending == 1'b1, "R4 model pending", 512'(pending), 512'(1));
    take_warp("R4 skip empty quad");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule